// File: doc/BRIEF.md
# Predicated Vector Reduction Engine

This block folds a vector of up to 64 elements into one scalar value, one element at a time. A start pulse hands it an operation code, a vector length, a sub-vector lane count and a per-element predicate mask. The engine walks the enabled elements in index order. It fetches each one through a valid/ready read port and folds it into a running value. It then writes that value into the first enabled destination slot. A done pulse closes every operation.

Each element may carry 1 to 4 lanes. The lanes can be reduced independently, with one result per lane. They can also be folded together into one scalar. Each combine step also produces a 3-bit sign/zero condition of its result. These conditions are merged across the steps with either any-of or all-of meaning. Requests that are not allowed are answered at once with an illegal pulse. These are subtract, divide, carry-using operations, zeroing predication and over-long vectors.

Top module: `pred_reduce_engine`

## Requirements
- R1: After reset, `done`, `illegal`, `rd_valid` and `wr_en` are low and `cond` is 000.
- R2: Operation codes 0 add, 1 multiply (low 64 bits), 2 signed minimum, 3 signed maximum, 4 bitwise OR and 5 bitwise AND. The running value starts as the first enabled element. Each later enabled element x is folded in ascending index order as run = op(run, x).
- R3: An accepted start with code 6 (subtract), code 7 (divide), `carry_req`=1, `zero_req`=1 or `vl` above 64 is rejected. `illegal` and `done` are then high together for one cycle, in the cycle after the start edge, and the request makes no read and no write.
- R4: Elements whose predicate bit is 0 are never read. Predicate bits at indices at or above `vl` are treated as 0. Writes go only to the first enabled element, and no other address is written.
- R5: With exactly one enabled element, its value is written unchanged. With none, nothing is written and `done` is still raised.
- R6: Each combine step gives flags {bit2 negative, bit1 positive, bit0 zero} of its signed result. With `crm`=0 the steps' flags are OR-merged, and with `crm`=1 they are AND-merged, across all lanes. `cond` is 000 when no combine step occurred. It is valid with `done` and held until the next accepted start.
- R7: `subvl` code n gives n+1 lanes. Read and write addresses are element*4 + lane. With `svm`=0, each lane is reduced on its own and written to (first enabled element, lane), in ascending lane order.
- R8: With `svm`=1, every lane of every enabled element is folded into one value. The order is element-major and lane-minor. It is written once, to (first enabled element, lane 0).
- R9: One predicate bit covers all lanes of its element, so the lanes are read or skipped together.
- R10: `rd_valid` stays high with a stable `rd_addr` until `rd_ready` is seen. Data is taken in the cycle where both are high.
- R11: A legal start with `vl`=0 raises `done` in the cycle after the start edge, with no read and no write.
- R12: `start` is ignored while an operation is in progress, and the running operation finishes with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Combine operation code |
| vl | input | 7 | Vector length in elements |
| subvl | input | 2 | Lane count minus one |
| svm | input | 1 | 1: fold all lanes together |
| crm | input | 1 | Condition merge: 0 any-of, 1 all-of |
| zero_req | input | 1 | Zeroing predication requested (illegal) |
| carry_req | input | 1 | Carry/overflow form requested (illegal) |
| pred | input | 64 | Per-element predicate mask |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 8 | Read address, element*4+lane |
| rd_ready | input | 1 | Read data present this cycle |
| rd_data | input | 64 | Read data |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 8 | Result address, element*4+lane |
| wr_data | output | 64 | Result value |
| cond | output | 3 | Merged condition flags |
| done | output | 1 | Operation finished (one-cycle pulse) |
| illegal | output | 1 | Request rejected (one-cycle pulse) |

## Verification
Rejections and zero-length requests must show `done` (and, for rejections, `illegal`) in the first cycle after the clock edge that sampled `start`. The bench reads them at the falling edge right after that edge. Result writes appear as one-cycle strobes before `done`. A monitor records them at each rising edge, so every write is logged before `done` is seen. `cond`, the write log and the read count are compared at the falling edge where `done` is first high. The same operations are repeated with a stalling `rd_ready` to show that the results do not depend on read latency.

// File: rtl/rv_pkg.sv
// Shared types for the predicated reduction engine.
// Assumes a 3-bit operation code; codes 6 and 7 are never executed.
package rv_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_MUL = 3'd1,
        OP_MIN = 3'd2,
        OP_MAX = 3'd3,
        OP_OR  = 3'd4,
        OP_AND = 3'd5,
        OP_SUB = 3'd6,
        OP_DIV = 3'd7
    } rv_op_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_SCAN = 2'd1,
        WS_PUT  = 2'd2
    } rv_walk_e;
endpackage

// File: rtl/rv_first_set.sv
// Lowest-index set bit finder.
// Assumes N >= 2; idx is 0 when no bit is set.
module rv_first_set #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rv_combine.sv
// One fold step: y = op(a, b) plus sign/zero flags of y.
// Assumes op codes 6/7 never reach here (filtered at start); they yield a.
module rv_combine #(
    parameter int DW = 64
) (
    input  rv_pkg::rv_op_e op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y,
    output logic [2:0]     flags
);
    import rv_pkg::*;

    logic a_lt_b;
    assign a_lt_b = $signed(a) < $signed(b);

    // operation select
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_MUL:  y = a * b;
            OP_MIN:  y = a_lt_b ? a : b;
            OP_MAX:  y = a_lt_b ? b : a;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            default: y = a;
        endcase
    end

    // flags {negative, positive, zero} of the step result
    always_comb begin
        flags[2] = y[DW-1];
        flags[0] = (y == '0);
        flags[1] = !y[DW-1] && (y != '0);
    end
endmodule

// File: rtl/rv_walker.sv
// Element/lane walker: steps through elements (and lanes), requests reads
// for enabled ones and opens one write slot per produced result.
// Assumes vl_q >= 1 whenever go is raised and pred_q is already range-masked.
module rv_walker #(
    parameter int MAX_VL = 64,
    localparam int EW  = $clog2(MAX_VL),
    localparam int VLW = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [VLW-1:0]    vl_q,
    input  logic [1:0]        lanes_m1_q,
    input  logic              svm_q,
    input  logic [MAX_VL-1:0] pred_q,
    input  logic              rd_ready,
    output logic              busy,
    output logic              rd_valid,
    output logic [EW-1:0]     elem,
    output logic [1:0]        lane,
    output logic              put,
    output logic              put_last
);
    import rv_pkg::*;

    rv_walk_e      st_q;
    logic [EW-1:0] e_q;
    logic [1:0]    l_q;
    logic          en, step, last_elem, last_lane;

    assign en        = pred_q[e_q];
    assign last_elem = (VLW'(e_q) == vl_q - VLW'(1));
    assign last_lane = (l_q == lanes_m1_q);
    assign rd_valid  = (st_q == WS_SCAN) && en;
    assign step      = (st_q == WS_SCAN) && (!en || rd_ready);
    assign put       = (st_q == WS_PUT);
    assign put_last  = svm_q || last_lane;
    assign busy      = (st_q != WS_IDLE);
    assign elem      = e_q;
    assign lane      = l_q;

    // walk state and element/lane counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WS_IDLE;
            e_q  <= '0;
            l_q  <= '0;
        end else begin
            unique case (st_q)
                WS_IDLE: if (go) begin
                    st_q <= WS_SCAN;
                    e_q  <= '0;
                    l_q  <= '0;
                end
                WS_SCAN: if (step) begin
                    if (last_elem && (!svm_q || last_lane)) begin
                        st_q <= WS_PUT;
                    end else if (svm_q && !last_lane) begin
                        l_q <= l_q + 2'd1;
                    end else begin
                        e_q <= e_q + EW'(1);
                        if (svm_q) l_q <= '0;
                    end
                end
                WS_PUT: if (put_last) begin
                    st_q <= WS_IDLE;
                end else begin
                    l_q  <= l_q + 2'd1;
                    e_q  <= '0;
                    st_q <= WS_SCAN;
                end
                default: st_q <= WS_IDLE;
            endcase
        end
    end

    AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (l_q <= lanes_m1_q)); // R7
    AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_SCAN) |-> (VLW'(e_q) < vl_q)); // R4
endmodule

// File: rtl/pred_reduce_engine.sv
// Predicated vector reduction engine top.
// Latches the request on an accepted start, rejects forbidden requests,
// folds enabled elements through rv_combine and writes the result(s) to
// the first enabled element. Assumes the read port returns data in the
// cycle rd_ready is high and that writes always complete in one cycle.
module pred_reduce_engine #(
    parameter int MAX_VL = 64,
    parameter int DW     = 64,
    localparam int EW  = $clog2(MAX_VL),
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int AW  = EW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [VLW-1:0]    vl,
    input  logic [1:0]        subvl,
    input  logic              svm,
    input  logic              crm,
    input  logic              zero_req,
    input  logic              carry_req,
    input  logic [MAX_VL-1:0] pred,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ready,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [2:0]        cond,
    output logic              done,
    output logic              illegal
);
    import rv_pkg::*;

    localparam logic [VLW-1:0] VL_LIMIT = VLW'(MAX_VL);

    logic              busy, take, put, put_last, go, accept, bad, vl_zero;
    logic [EW-1:0]     elem, first_e;
    logic [1:0]        lane, wr_lane;
    logic              first_ok;
    logic [MAX_VL-1:0] in_rng, pred_q;
    logic [VLW-1:0]    vl_q;
    logic [1:0]        lanes_m1_q;
    logic              svm_q, crm_q;
    rv_op_e            op_q;
    logic [DW-1:0]     acc_q, step_y;
    logic              acc_vld_q;
    logic [2:0]        step_f, cond_q;
    logic              cond_any_q, done_q, ill_q;

    // range mask: predicate bits at or above vl never count
    for (genvar i = 0; i < MAX_VL; i++) begin : g_rng
        assign in_rng[i] = (VLW'(i) < vl);
    end

    assign accept  = start && !busy;
    assign bad     = (op == OP_SUB) || (op == OP_DIV) || zero_req || carry_req
                     || (vl > VL_LIMIT);
    assign vl_zero = (vl == '0);
    assign go      = accept && !bad && !vl_zero;
    assign take    = rd_valid && rd_ready;

    // request latch on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q       <= '0;
            lanes_m1_q <= '0;
            svm_q      <= 1'b0;
            crm_q      <= 1'b0;
            op_q       <= OP_ADD;
            pred_q     <= '0;
        end else if (accept) begin
            vl_q       <= vl;
            lanes_m1_q <= subvl;
            svm_q      <= svm;
            crm_q      <= crm;
            op_q       <= rv_op_e'(op);
            pred_q     <= pred & in_rng;
        end
    end

    rv_first_set #(.N(MAX_VL)) u_first (
        .vec   (pred_q),
        .idx   (first_e),
        .found (first_ok)
    );

    rv_walker #(.MAX_VL(MAX_VL)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .vl_q       (vl_q),
        .lanes_m1_q (lanes_m1_q),
        .svm_q      (svm_q),
        .pred_q     (pred_q),
        .rd_ready   (rd_ready),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .elem       (elem),
        .lane       (lane),
        .put        (put),
        .put_last   (put_last)
    );

    rv_combine #(.DW(DW)) u_comb (
        .op    (op_q),
        .a     (acc_q),
        .b     (rd_data),
        .y     (step_y),
        .flags (step_f)
    );

    // running value: first enabled element seeds it, later ones fold in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            acc_vld_q <= 1'b0;
        end else if (accept) begin
            acc_vld_q <= 1'b0;
        end else if (take) begin
            acc_q     <= acc_vld_q ? step_y : rd_data;
            acc_vld_q <= 1'b1;
        end else if (put && !put_last) begin
            acc_vld_q <= 1'b0;
        end
    end

    // condition merge over combine steps (any-of / all-of)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q     <= '0;
            cond_any_q <= 1'b0;
        end else if (accept) begin
            cond_q     <= '0;
            cond_any_q <= 1'b0;
        end else if (take && acc_vld_q) begin
            cond_any_q <= 1'b1;
            if (!cond_any_q)  cond_q <= step_f;
            else if (crm_q)   cond_q <= cond_q & step_f;
            else              cond_q <= cond_q | step_f;
        end
    end

    // completion and rejection pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            done_q <= (accept && (bad || vl_zero)) || (put && put_last);
            ill_q  <= accept && bad;
        end
    end

    assign wr_lane = svm_q ? 2'd0 : lane;
    assign rd_addr = {elem, lane};
    assign wr_en   = put && acc_vld_q && first_ok;
    assign wr_addr = {first_e, wr_lane};
    assign wr_data = acc_q;
    assign cond    = cond_q;
    assign done    = done_q;
    assign illegal = ill_q;

    AST_ILL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done); // R3
    AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_valid && !wr_en)); // R3
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R10
    AST_RD_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> pred_q[rd_addr[AW-1:2]]); // R4
    AST_WR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> pred_q[wr_addr[AW-1:2]]); // R4
    AST_SVM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && svm_q) |-> (wr_addr[1:0] == 2'd0)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
endmodule

// File: tb/sim_pred_reduce_engine.sv
module sim_pred_reduce_engine;
    typedef struct packed {
        logic [2:0]  op;
        logic [6:0]  vl;
        logic [1:0]  sv;
        logic        svm;
        logic        crm;
        logic [63:0] pred;
    } vec_t;

    function automatic vec_t mk(logic [2:0] o, logic [6:0] v, logic [1:0] s,
                                logic m, logic c, logic [63:0] p);
        vec_t t;
        t.op = o; t.vl = v; t.sv = s; t.svm = m; t.crm = c; t.pred = p;
        return t;
    endfunction

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        mk(3'd0, 7'd8,  2'd0, 1'b0, 1'b0, 64'hFF),               // R2 add
        mk(3'd1, 7'd5,  2'd0, 1'b0, 1'b0, 64'h1A),               // R2 mul
        mk(3'd2, 7'd16, 2'd0, 1'b0, 1'b0, 64'hF0F0),             // R2 min
        mk(3'd3, 7'd16, 2'd0, 1'b0, 1'b1, 64'h0F0F),             // R2 max, R6 all-of
        mk(3'd4, 7'd64, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF), // R2 or
        mk(3'd5, 7'd64, 2'd0, 1'b0, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA), // R2 and
        mk(3'd0, 7'd10, 2'd3, 1'b0, 1'b0, 64'h2C4),              // R7 per-lane
        mk(3'd3, 7'd6,  2'd2, 1'b1, 1'b0, 64'h26),               // R8 folded lanes
        mk(3'd2, 7'd3,  2'd1, 1'b0, 1'b1, 64'h4),                // R5 single
        mk(3'd0, 7'd4,  2'd0, 1'b0, 1'b0, 64'h0),                // R5 none
        mk(3'd4, 7'd4,  2'd0, 1'b0, 1'b0, 64'hF0)                // R4 bits beyond vl
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [6:0]  vl = '0;
    logic [1:0]  subvl = '0;
    logic        svm = 1'b0, crm = 1'b0, zero_req = 1'b0, carry_req = 1'b0;
    logic [63:0] pred = '0;
    logic        rd_valid, rd_ready, wr_en, done, illegal;
    logic [7:0]  rd_addr, wr_addr;
    logic [63:0] rd_data, wr_data;
    logic [2:0]  cond;
    logic        stall = 1'b0;
    int          cyc = 0;

    int checks = 0, fails = 0;
    logic [7:0]  wl_addr [8];
    logic [63:0] wl_data [8];
    int          wl_n = 0, rd_n = 0, bad_rd = 0, done_n = 0;
    logic [63:0] cur_pred = '0;

    logic [7:0]  x_addr [4];
    logic [63:0] x_data [4];
    int          x_n, x_rd;
    logic [2:0]  x_cond;
    logic        x_any;
    logic [63:0] x_acc;
    logic        x_av;

    always #4 clk = ~clk;

    function automatic logic [63:0] src_val(logic [7:0] a);
        return (64'(a) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
    endfunction

    assign rd_data  = src_val(rd_addr);
    assign rd_ready = stall ? cyc[1] : 1'b1;

    pred_reduce_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vl(vl),
        .subvl(subvl), .svm(svm), .crm(crm), .zero_req(zero_req),
        .carry_req(carry_req), .pred(pred), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cond(cond),
        .done(done), .illegal(illegal)
    );

    // port monitor and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) begin
            if (wl_n < 8) begin
                wl_addr[wl_n] = wr_addr;
                wl_data[wl_n] = wr_data;
            end
            wl_n = wl_n + 1;
        end
        if (rd_valid && rd_ready) begin
            rd_n = rd_n + 1;
            if (!cur_pred[rd_addr[7:2]]) bad_rd = bad_rd + 1;
        end
        if (done) done_n = done_n + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_op(logic [2:0] o, logic [63:0] a, logic [63:0] b);
        case (o)
            3'd0: return a + b;
            3'd1: return a * b;
            3'd2: return ($signed(a) < $signed(b)) ? a : b;
            3'd3: return ($signed(a) < $signed(b)) ? b : a;
            3'd4: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic fold(input vec_t v, input logic [63:0] x);
        logic [2:0] f;
        x_rd = x_rd + 1;
        if (!x_av) begin
            x_acc = x;
            x_av  = 1'b1;
        end else begin
            x_acc = ref_op(v.op, x_acc, x);
            f = {x_acc[63], !x_acc[63] && (x_acc != 0), x_acc == 0};
            if (!x_any) x_cond = f;
            else if (v.crm) x_cond = x_cond & f;
            else x_cond = x_cond | f;
            x_any = 1'b1;
        end
    endtask

    // reference from the requirements: R2, R5, R6, R7, R8, R9
    task automatic model(input vec_t v);
        int first;
        first = -1;
        x_n = 0; x_rd = 0; x_cond = 3'b000; x_any = 1'b0;
        for (int e = v.vl - 1; e >= 0; e--) if (v.pred[e]) first = e;
        if (v.svm) begin
            x_av = 1'b0;
            for (int e = 0; e < v.vl; e++)
                if (v.pred[e])
                    for (int l = 0; l <= v.sv; l++) fold(v, src_val(8'(e * 4 + l)));
            if (x_av) begin
                x_addr[0] = 8'(first * 4); x_data[0] = x_acc; x_n = 1;
            end
        end else begin
            for (int l = 0; l <= v.sv; l++) begin
                x_av = 1'b0;
                for (int e = 0; e < v.vl; e++)
                    if (v.pred[e]) fold(v, src_val(8'(e * 4 + l)));
                if (x_av) begin
                    x_addr[x_n] = 8'(first * 4 + l); x_data[x_n] = x_acc; x_n = x_n + 1;
                end
            end
        end
    endtask

    task automatic launch(input vec_t v, input bit zr, input bit cr);
        @(negedge clk);
        op = v.op; vl = v.vl; subvl = v.sv; svm = v.svm; crm = v.crm;
        pred = v.pred; zero_req = zr; carry_req = cr;
        cur_pred = v.pred;
        wl_n = 0; rd_n = 0; bad_rd = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done;
        int t;
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_vec(input vec_t v, input string req);
        model(v);
        launch(v, 1'b0, 1'b0);
        wait_done();
        check(done == 1'b1, req, "done raised", 64'(done), 64'd1);
        check(illegal == 1'b0, req, "no illegal", 64'(illegal), 64'd0);
        check(wl_n == x_n, req, "write count", 64'(wl_n), 64'(x_n));
        for (int i = 0; i < x_n && i < wl_n; i++) begin
            check(wl_addr[i] == x_addr[i], req, "write address", 64'(wl_addr[i]), 64'(x_addr[i]));
            check(wl_data[i] == x_data[i], req, "write data", wl_data[i], x_data[i]);
        end
        check(cond == x_cond, "R6", "condition", 64'(cond), 64'(x_cond));
        check(rd_n == x_rd && bad_rd == 0, "R4 R9", "reads of enabled lanes only",
              64'(rd_n), 64'(x_rd));
    endtask

    task automatic run_ill(input logic [2:0] o, input logic [6:0] l, input bit zr,
                           input bit cr, input string what);
        launch(mk(o, l, 2'd0, 1'b0, 1'b0, 64'hF), zr, cr);
        check(illegal == 1'b1 && done == 1'b1, "R3", what, {62'd0, illegal, done}, 64'd3);
        @(negedge clk);
        check(wl_n == 0 && rd_n == 0, "R3", {what, " quiet"}, 64'(wl_n + rd_n), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!done && !illegal && !rd_valid && !wr_en, "R1", "idle outputs",
              {60'd0, done, illegal, rd_valid, wr_en}, 64'd0);
        check(cond == 3'b000, "R1", "cond after reset", 64'(cond), 64'd0);

        // vector table
        for (int i = 0; i < NV; i++) run_vec(TBL[i], "R2 R4 R5 R7 R8");

        // R10 same operations with a stalling read port
        stall = 1'b1;
        run_vec(TBL[6], "R10 stall lanes");
        run_vec(TBL[2], "R10 stall min");
        stall = 1'b0;

        // R3 rejections
        run_ill(3'd6, 7'd4, 1'b0, 1'b0, "subtract rejected");
        run_ill(3'd7, 7'd4, 1'b0, 1'b0, "divide rejected");
        run_ill(3'd0, 7'd4, 1'b1, 1'b0, "zeroing rejected");
        run_ill(3'd0, 7'd4, 1'b0, 1'b1, "carry rejected");
        run_ill(3'd0, 7'd65, 1'b0, 1'b0, "vl above 64 rejected");

        // R11 zero length
        launch(mk(3'd0, 7'd0, 2'd0, 1'b0, 1'b0, 64'hFF), 1'b0, 1'b0);
        check(done == 1'b1 && illegal == 1'b0, "R11", "vl=0 done next cycle",
              {62'd0, done, illegal}, 64'd2);
        @(negedge clk);
        check(wl_n == 0 && rd_n == 0, "R11", "vl=0 no access", 64'(wl_n + rd_n), 64'd0);

        // R12 start while busy is ignored
        model(TBL[0]);
        launch(TBL[0], 1'b0, 1'b0);
        done_n = 0;
        op = 3'd1; vl = 7'd2; pred = 64'h3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        check(wl_n == 1 && wl_data[0] == x_data[0], "R12", "running op unaffected",
              wl_data[0], x_data[0]);
        check(done_n == 1, "R12", "single done", 64'(done_n), 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule